// File: doc/BRIEF.md
# Gated Fractional Reference Clock Divider Bank

The block derives four slower clock-enable strobes from one fast source clock. Every channel owns one byte of a shared 32-bit control word. That byte holds a 6-bit divide value F and a stop bit. While the stop bit is low, the channel emits single-cycle enable pulses whose long-run density is 18/F of the source rate. F values between 18 and 35 therefore span everything from every source cycle down to roughly every other cycle. Logic downstream of the block qualifies its flops with these strobes instead of running on a separate clock.

Software reaches the control word through three write strobes that share one data bus. A plain write replaces the whole word. A set write turns on only the bits that are 1 in the data. A clear write turns off only the bits that are 1 in the data. The set and clear writes let one channel be started or stopped without disturbing the other three. The read port shows the stored word combinationally.

Top module: `refdiv_bank`

## Requirements
- R1: After synchronous reset the read port returns 32'h92929292 (every byte: stop bit 1, divide value 18) and all four enable outputs are 0.
- R2: A plain write (`wr_en`) stores `wdata` into the whole word, except the reserved bits named in R5.
- R3: A set write (`set_en`) ORs `wdata` into the word. Bits that are 0 in `wdata` keep their value.
- R4: A clear write (`clr_en`) clears every word bit that is 1 in `wdata`. Bits that are 0 in `wdata` keep their value.
- R5: Bit 8n+6 of each byte n always reads 0, whatever is written to it.
- R6: Channel n's stop bit is bit 8n+7.
  - While it is 1, the channel's enable (`clk_en_o[n]`) stays 0 and its accumulator stays 0.
  - After the bit is cleared, pulses follow R7 starting from an accumulator of 0. With F=18 the first pulse appears in the second cycle after the clearing write's edge. With F=35 it appears one cycle later.
- R7: Channel n's divide value sits in bits [8n+5:8n].
  - Every ungated cycle the channel adds 18 to a 6-bit accumulator. When the sum is at least F, the channel subtracts F and emits a one-cycle enable pulse.
  - Starting from 0, F consecutive cycles contain exactly 18 pulses.
- R8: A divide value below 18 behaves as 18 (a pulse every cycle). A value above 35 behaves as 35.
- R9: A new divide value governs the channel from the cycle after its write. The accumulator is not cleared by the change.
- R10: When several write strobes are active in one cycle, the plain write takes effect over set, and set takes effect over clear. Only one of them is applied.
- R11: The read port reflects a write in the cycle immediately after the write's clock edge, with no added read latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Plain write strobe (replace word) |
| set_en | input | 1 | Bit-set write strobe |
| clr_en | input | 1 | Bit-clear write strobe |
| wdata | input | 32 | Write data shared by all three strobes |
| rdata | output | 32 | Current control word |
| clk_en_o | output | 4 | Per-channel one-cycle clock-enable pulses |

## Verification
The hardest situation to reach from the ports is a divide change that lands while a channel's accumulator holds a nonzero remainder. In that case the next pulse depends on the remainder carried across the change, not on a fresh start. The stimulus produces it by leaving all channels running at the upper clamp for an uneven number of cycles. It then rewrites one channel's field with a read-modify-write of the whole word. A cycle-accurate scoreboard model follows every accumulator and flags any pulse placed one cycle off. Directed pulse counts over whole F-cycle windows confirm the long-run rate and both clamps.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

    localparam int N_CH    = 4;
    localparam int FRAC_W  = 6;
    localparam int PAD_W   = 1;
    localparam int LANE_W  = FRAC_W + PAD_W + 1;
    localparam int SUM_W   = FRAC_W + 1;

    localparam logic [FRAC_W-1:0] NUMER   = FRAC_W'(18);
    localparam logic [FRAC_W-1:0] FRAC_LO = FRAC_W'(18);
    localparam logic [FRAC_W-1:0] FRAC_HI = FRAC_W'(35);

    typedef struct packed {
        logic              stop;
        logic [PAD_W-1:0]  pad;
        logic [FRAC_W-1:0] frac;
    } lane_t;

    localparam logic [LANE_W-1:0] LANE_KEEP = {1'b1, {PAD_W{1'b0}}, {FRAC_W{1'b1}}};
    localparam lane_t LANE_RST = '{stop: 1'b1, pad: '0, frac: FRAC_LO};

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_SET   = 2'd2,
        OP_CLEAR = 2'd3
    } wr_op_e;

    function automatic logic [FRAC_W-1:0] clamp_frac(input logic [FRAC_W-1:0] f);
        if (f < FRAC_LO)      return FRAC_LO;
        else if (f > FRAC_HI) return FRAC_HI;
        else                  return f;
    endfunction

    function automatic lane_t to_lane(input logic [LANE_W-1:0] bits);
        lane_t l;
        l = lane_t'(bits & LANE_KEEP);
        return l;
    endfunction

    function automatic wr_op_e pick_op(input logic wr, input logic st, input logic cl);
        if (wr)      return OP_WRITE;
        else if (st) return OP_SET;
        else if (cl) return OP_CLEAR;
        else         return OP_NONE;
    endfunction

endpackage

// File: rtl/refdiv_regbank.sv
module refdiv_regbank
    import refdiv_pkg::*;
#(
    parameter int NUM_CH = N_CH,
    localparam int REG_W = NUM_CH * LANE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             set_en,
    input  logic             clr_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] word_o,
    output lane_t            lanes_o [NUM_CH]
);

    wr_op_e           op;
    logic [REG_W-1:0] keep;

    always_comb op = pick_op(wr_en, set_en, clr_en);

    for (genvar n = 0; n < NUM_CH; n++) begin : g_lane
        lane_t             cur_q;
        lane_t             nxt;
        logic [LANE_W-1:0] wd;

        assign wd = wdata[n*LANE_W +: LANE_W];
        assign keep[n*LANE_W +: LANE_W] = LANE_KEEP;

        always_comb begin
            unique case (op)
                OP_WRITE: nxt = to_lane(wd);
                OP_SET:   nxt = to_lane(LANE_W'(cur_q) | wd);
                OP_CLEAR: nxt = to_lane(LANE_W'(cur_q) & ~wd);
                default:  nxt = cur_q;
            endcase
        end

        always_ff @(posedge clk) begin
            if (rst) cur_q <= LANE_RST;
            else     cur_q <= nxt;
        end

        assign word_o[n*LANE_W +: LANE_W] = LANE_W'(cur_q);
        assign lanes_o[n] = cur_q;

        // R5: reserved bit of each lane never holds a 1
        a_r5_pad_zero: assert property (@(posedge clk) disable iff (rst)
            cur_q.pad == '0);
    end

    // R2: plain write replaces the word (reserved bits masked)
    a_r2_plain_write: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> word_o == ($past(wdata) & keep));

    // R3, R10: set write ORs data in when no plain write is present
    a_r3_set_or: assert property (@(posedge clk) disable iff (rst)
        (set_en && !wr_en) |=> word_o == (($past(word_o) | $past(wdata)) & keep));

    // R4, R10: clear write removes the 1-bits of the data when alone
    a_r4_clear_and: assert property (@(posedge clk) disable iff (rst)
        (clr_en && !set_en && !wr_en) |=> word_o == ($past(word_o) & ~$past(wdata)));

endmodule

// File: rtl/refdiv_chan.sv
module refdiv_chan
    import refdiv_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  lane_t cfg,
    output logic  en_o
);

    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W-1:0] frac_eff;
    logic [SUM_W-1:0]  sum;
    logic              hit;
    logic [SUM_W-1:0]  rem;

    always_comb begin
        frac_eff = clamp_frac(cfg.frac);
        sum      = {1'b0, acc_q} + SUM_W'(NUMER);
        hit      = sum >= {1'b0, frac_eff};
        rem      = sum - {1'b0, frac_eff};
    end

    always_ff @(posedge clk) begin
        if (rst || cfg.stop) begin
            acc_q <= '0;
            en_o  <= 1'b0;
        end else begin
            en_o  <= hit;
            acc_q <= hit ? rem[FRAC_W-1:0] : sum[FRAC_W-1:0];
        end
    end

    // R6: a stopped channel emits nothing in the following cycle
    a_r6_gate_quiet: assert property (@(posedge clk) disable iff (rst)
        cfg.stop |=> (!en_o && acc_q == '0));

    // R7: remainder stays below the largest effective divide value
    a_r7_acc_bounded: assert property (@(posedge clk) disable iff (rst)
        acc_q < FRAC_HI);

    // R8: a divide value at or below the lower clamp pulses every running cycle
    a_r8_low_clamp_full_rate: assert property (@(posedge clk) disable iff (rst)
        (!cfg.stop && cfg.frac <= FRAC_LO) |=> en_o);

endmodule

// File: rtl/refdiv_bank.sv
module refdiv_bank
    import refdiv_pkg::*;
#(
    parameter int NUM_CH = N_CH,
    localparam int REG_W = NUM_CH * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              set_en,
    input  logic              clr_en,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic [NUM_CH-1:0] clk_en_o
);

    lane_t lanes [NUM_CH];

    refdiv_regbank #(.NUM_CH(NUM_CH)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .set_en  (set_en),
        .clr_en  (clr_en),
        .wdata   (wdata),
        .word_o  (rdata),
        .lanes_o (lanes)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        refdiv_chan u_chan (
            .clk  (clk),
            .rst  (rst),
            .cfg  (lanes[n]),
            .en_o (clk_en_o[n])
        );
    end

    // R1: outputs stay quiet in the cycle after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        rst |=> clk_en_o == '0);

endmodule

// File: tb/sim_refdiv_bank.sv
module sim_refdiv_bank;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, set_en = 1'b0, clr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  clk_en_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    refdiv_bank u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .set_en(set_en), .clr_en(clr_en),
        .wdata(wdata), .rdata(rdata), .clk_en_o(clk_en_o)
    );

    // ---------------- scoreboard: model pushes, monitor pops ----------------
    logic [35:0] exp_q [$];
    logic [31:0] mreg;
    int          macc [4];

    always @(posedge clk) begin
        logic [3:0] en;
        if (rst) begin
            mreg = 32'h92929292;
            for (int n = 0; n < 4; n++) macc[n] = 0;
            en = '0;
        end else begin
            for (int n = 0; n < 4; n++) begin
                int f;
                f = int'(mreg[8*n +: 6]);
                if (f < 18) f = 18;
                if (f > 35) f = 35;
                if (mreg[8*n+7]) begin
                    macc[n] = 0;
                    en[n] = 1'b0;
                end else begin
                    macc[n] = macc[n] + 18;
                    en[n] = (macc[n] >= f);
                    if (en[n]) macc[n] = macc[n] - f;
                end
            end
            if (wr_en)       mreg = wdata & 32'hBFBFBFBF;
            else if (set_en) mreg = (mreg | wdata) & 32'hBFBFBFBF;
            else if (clr_en) mreg = mreg & ~wdata;
        end
        exp_q.push_back({en, mreg});
    end

    always @(negedge clk) begin
        logic [35:0] e;
        if (!done && exp_q.size() > 0) begin
            e = exp_q.pop_front();
            n_tests++;
            if (clk_en_o !== e[35:32]) begin
                n_fail++;
                $display("FAIL R7 scoreboard enable: got %b expected %b", clk_en_o, e[35:32]);
            end
            n_tests++;
            if (rdata !== e[31:0]) begin
                n_fail++;
                $display("FAIL R2 scoreboard word: got %h expected %h", rdata, e[31:0]);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic w, input logic s, input logic c, input logic [31:0] d);
        @(negedge clk);
        wr_en = w; set_en = s; clr_en = c; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; set_en = 1'b0; clr_en = 1'b0; wdata = '0;
    endtask

    task automatic count_pulses(input int ch, input int ncyc, output int cnt,
                                output logic first, output logic second);
        cnt = 0; first = 1'b0; second = 1'b0;
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            if (clk_en_o[ch]) cnt++;
            if (i == 0) first = clk_en_o[ch];
            if (i == 1) second = clk_en_o[ch];
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    // ---------------- directed sequence ----------------
    initial begin
        int   cnt;
        logic f1, f2;
        logic [31:0] w;
        logic quiet;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset word", rdata, 32'h92929292);
        check("R1 reset enables", {28'd0, clk_en_o}, 32'd0);

        // R4: clear channel 0 stop bit; R6/R7 rate 18 -> every cycle
        drive(1'b0, 1'b0, 1'b1, 32'h00000080);
        check("R4 clear stop bit", rdata, 32'h92929212);
        count_pulses(0, 18, cnt, f1, f2);
        check("R6 first pulse after release", {31'd0, f1}, 32'd1);
        check("R7 pulses in 18 cycles at F=18", cnt, 32'd18);

        // R3: set stop bit again; R6: channel stays quiet
        drive(1'b0, 1'b1, 1'b0, 32'h00000080);
        check("R3 set stop bit", rdata, 32'h92929292);
        quiet = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (clk_en_o != 4'b0000) quiet = 1'b0;
        end
        check("R6 gated channels silent", {31'd0, quiet}, 32'd1);

        // R2/R5/R11: plain write of all ones, reserved bits drop
        drive(1'b1, 1'b0, 1'b0, 32'hFFFFFFFF);
        check("R2 R5 R11 plain write masks reserved bit", rdata, 32'hBFBFBFBF);

        // R8 upper clamp: F=63 acts as 35
        drive(1'b0, 1'b0, 1'b1, 32'h80808080);
        check("R4 clear all stop bits", rdata, 32'h3F3F3F3F);
        count_pulses(0, 35, cnt, f1, f2);
        check("R6 F=35 first sample", {31'd0, f1}, 32'd0);
        check("R6 F=35 second sample", {31'd0, f2}, 32'd1);
        check("R8 pulses in 35 cycles at clamped F", cnt, 32'd18);

        // run an uneven stretch so accumulators hold remainders
        repeat (7) @(negedge clk);

        // R8 lower clamp, via read-modify-write of channel 1 to F=5
        w = (rdata & ~32'h00003F00) | 32'h00000500;
        drive(1'b1, 1'b0, 1'b0, w);
        check("R2 read-modify-write", rdata, 32'h3F3F053F);
        count_pulses(1, 18, cnt, f1, f2);
        check("R8 low clamp full rate", cnt, 32'd18);

        // R9: channel 2 from 35 to 18 takes effect next cycle
        w = (rdata & ~32'h003F0000) | 32'h00120000;
        drive(1'b1, 1'b0, 1'b0, w);
        check("R9 new field stored", rdata, 32'h3F12053F);
        count_pulses(2, 5, cnt, f1, f2);
        check("R9 new divide applies next cycle", {31'd0, f1}, 32'd1);
        check("R9 full rate after change", cnt, 32'd5);

        // R10: priority among strobes
        drive(1'b1, 1'b1, 1'b1, 32'h00000080);
        check("R10 plain write over set and clear", rdata, 32'h00000080);
        drive(1'b0, 1'b1, 1'b1, 32'h80000000);
        check("R10 set over clear", rdata, 32'h80000080);
        drive(1'b0, 1'b0, 1'b1, 32'h00000080);
        check("R4 clear leaves other bits", rdata, 32'h80000000);

        repeat (40) @(negedge clk);
        finish_run();
    end

endmodule